// File: doc/BRIEF.md
# Carry-predicting approximate split adder

This block is a purely combinational adder that gives up exactness in its low-order bits to save logic. It is meant for error-tolerant datapaths such as filtering, clustering and other signal arithmetic. The operands are split at a fixed point. The high `EXACT_W` bits go through a true ripple-carry adder. The low `WIDTH-EXACT_W` bits are only approximated.

The approximated field has three regions.

- **Filled region.** The lowest `FILL_W` result bits are wired to one. This region has no gates and produces no carry.
- **OR region.** Above the filled region, each result bit is the OR of its two operand bits and of a carry guessed one position below. The guessed carry at any position is the AND of that position's operand bits.
- **Half-adder bit.** The topmost approximate position uses XOR in place of OR. Together with its AND carry it forms a real half adder.

The AND of the operand bits at the topmost approximate position is the carry fed into the exact part. The carry out of the exact part is a separate output. All three widths are elaboration parameters, and illegal combinations stop elaboration.

Top module: `approx_split_adder`

## Requirements
- R1: With m = WIDTH-EXACT_W, the value {carry_out, sum[WIDTH-1:m]} equals a[WIDTH-1:m] + b[WIDTH-1:m] + (a[m-1] & b[m-1]), computed in EXACT_W+1 bits.
- R2: The only carry reaching the exact part is a[m-1] & b[m-1]. Operand bits below position m-1 never change sum[WIDTH-1:m] or carry_out.
- R3: For each position i with FILL_W <= i <= m-2, sum[i] = a[i] | b[i] | (a[i-1] & b[i-1]). At i = FILL_W the carry term is 0.
- R4: sum[m-1] = (a[m-1] ^ b[m-1]) | (a[m-2] & b[m-2]). The carry term is dropped when m-1 = FILL_W.
- R5: sum[FILL_W-1:0] is all ones for every pair of operands.
- R6: The full result {carry_out, sum} equals the exact a + b whenever two conditions hold: no position in FILL_W..m-2 has both operand bits set, and every position below FILL_W has differing operand bits. In particular, with m = 1 and FILL_W = 0 the block is an exact adder.
- R7: The absolute difference between {carry_out, sum} and the exact a + b is always below 2^(m+1).
- R8: For uniformly random operands, the fraction of results that differ from the exact sum matches 1 - (3/4)^(m-FILL_W-1) * (1/2)^FILL_W within 0.015.
- R9: Elaboration fails unless 1 <= EXACT_W < WIDTH and 0 <= FILL_W <= m-1. The structure is correct at both limits, including an empty OR region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | WIDTH | first operand |
| b | input | WIDTH | second operand |
| sum | output | WIDTH | approximate sum, low WIDTH bits |
| carry_out | output | 1 | carry out of the exact upper part |

## Verification
The hardest case to reach is the one where a guessed carry has to cross the boundary between regions. Examples are a carry born at the top of the filled region, which must be dropped, and a carry from position m-2, which must set the half-adder bit. Random operands rarely isolate either case, so directed vectors set a single shared bit at each boundary position.

Two small configurations are swept exhaustively so that every structural variant is exercised: one with an empty OR region, and one whose approximate field is a single bit. A long random run on the default and zero-fill widths compares the results bit by bit with a model of the equations, and measures the error rate against the closed form.

// File: rtl/approx_split_adder.sv
module approx_split_adder #(
  parameter int WIDTH   = 16,
  parameter int EXACT_W = 8,
  parameter int FILL_W  = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);
  localparam int APPROX_W = WIDTH - EXACT_W;
  localparam int TOP      = APPROX_W - 1;
  localparam logic [APPROX_W-1:0] FILL_MASK = APPROX_W'((64'd1 << FILL_W) - 64'd1);
  localparam logic [APPROX_W-1:0] OR_MASK   = APPROX_W'((64'd1 << TOP) - 64'd1) & ~FILL_MASK;
  localparam logic [WIDTH+1:0]    ERR_LIM   = (WIDTH+2)'(64'd1 << (APPROX_W + 1));

  if (EXACT_W < 1 || EXACT_W >= WIDTH || FILL_W < 0 || FILL_W > TOP) begin : g_bad_params_r9
    $error("approx_split_adder: illegal WIDTH/EXACT_W/FILL_W");
  end

  logic [APPROX_W-1:0] gen;
  logic [APPROX_W-1:0] lo_sum;
  logic [EXACT_W:0]    rc;

  assign gen = a[TOP:0] & b[TOP:0];

  for (genvar i = 0; i < APPROX_W; i++) begin : g_lo
    if (i < FILL_W) begin : g_fill
      assign lo_sum[i] = 1'b1;
    end else if (i == TOP) begin : g_half
      if (i == FILL_W) begin : g_nocarry
        assign lo_sum[i] = a[i] ^ b[i];
      end else begin : g_carry
        assign lo_sum[i] = (a[i] ^ b[i]) | gen[i-1];
      end
    end else if (i == FILL_W) begin : g_or_first
      assign lo_sum[i] = a[i] | b[i];
    end else begin : g_or
      assign lo_sum[i] = a[i] | b[i] | gen[i-1];
    end
  end

  assign rc[0] = gen[TOP];

  for (genvar j = 0; j < EXACT_W; j++) begin : g_hi
    logic p;
    assign p                   = a[APPROX_W+j] ^ b[APPROX_W+j];
    assign sum[APPROX_W+j]     = p ^ rc[j];
    assign rc[j+1]             = (a[APPROX_W+j] & b[APPROX_W+j]) | (p & rc[j]);
  end

  assign sum[TOP:0] = lo_sum;
  assign carry_out  = rc[EXACT_W];

  logic [WIDTH:0]   exact_total;
  logic [WIDTH:0]   appr_total;
  logic [EXACT_W:0] hi_ref;
  logic [WIDTH+1:0] err_mag;
  logic             clean;

  assign exact_total = {1'b0, a} + {1'b0, b};
  assign appr_total  = {carry_out, sum};
  assign hi_ref      = {1'b0, a[WIDTH-1:APPROX_W]} + {1'b0, b[WIDTH-1:APPROX_W]}
                     + (EXACT_W+1)'(a[TOP] & b[TOP]);
  assign err_mag     = (appr_total > exact_total) ? (WIDTH+2)'(appr_total - exact_total)
                                                  : (WIDTH+2)'(exact_total - appr_total);
  assign clean       = ((gen & OR_MASK) == '0)
                    && ((((a[TOP:0] ^ b[TOP:0]) & FILL_MASK)) == FILL_MASK);

  always_comb begin
    p_upper_exact_r1: assert ({carry_out, sum[WIDTH-1:APPROX_W]} == hi_ref)
      else $error("R1 upper part mismatch");
    p_or_covers_r3: assert ((((a[TOP:0] | b[TOP:0]) & OR_MASK) & ~lo_sum) == '0)
      else $error("R3 OR region lost an operand bit");
    p_exact_when_clean_r6: assert (!clean || appr_total == exact_total)
      else $error("R6 error under clean operands");
    p_err_bound_r7: assert (err_mag < ERR_LIM)
      else $error("R7 error bound exceeded");
  end
endmodule

// File: tb/tb_approx_split_adder.sv
module tb_approx_split_adder;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [15:0] aw, bw;
  logic [7:0]  an, bn;
  logic [15:0] s_d, s_l0;
  logic [7:0]  s_e, s_z;
  logic        c_d, c_l0, c_e, c_z;

  approx_split_adder #(.WIDTH(16), .EXACT_W(8), .FILL_W(4)) dut
    (.a(aw), .b(bw), .sum(s_d), .carry_out(c_d));
  approx_split_adder #(.WIDTH(16), .EXACT_W(8), .FILL_W(0)) dut_l0
    (.a(aw), .b(bw), .sum(s_l0), .carry_out(c_l0));
  approx_split_adder #(.WIDTH(8), .EXACT_W(4), .FILL_W(3)) dut_e
    (.a(an), .b(bn), .sum(s_e), .carry_out(c_e));
  approx_split_adder #(.WIDTH(8), .EXACT_W(7), .FILL_W(0)) dut_z
    (.a(an), .b(bn), .sum(s_z), .carry_out(c_z));

  // {a, b, expected sum, expected carry_out} for WIDTH=16, EXACT_W=8, FILL_W=4
  localparam logic [48:0] VEC [11] = '{
    {16'h0000, 16'h0000, 16'h000F, 1'b0},  // R5 fill with zero operands
    {16'hFFFF, 16'h0001, 16'hFFFF, 1'b0},  // R2 low carries never reach exact part
    {16'h0080, 16'h0080, 16'h010F, 1'b0},  // R1 predicted carry from top approx bit
    {16'hFF80, 16'h0080, 16'h000F, 1'b1},  // R1 carry_out from exact part
    {16'h0040, 16'h0040, 16'h00CF, 1'b0},  // R4 carry from m-2 sets half-adder bit
    {16'h1210, 16'h2110, 16'h333F, 1'b0},  // R3 carry from first OR bit to next
    {16'hA5A5, 16'h5A5A, 16'hFFFF, 1'b0},  // R6 clean operands give exact sum
    {16'h0008, 16'h0008, 16'h000F, 1'b0},  // R3 first OR bit sees no carry
    {16'h7F00, 16'h0100, 16'h800F, 1'b0},  // R1 exact ripple
    {16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b1},  // R7 worst case saturation
    {16'h000F, 16'h000F, 16'h000F, 1'b0}   // R5 fill ignores ones
  };

  function automatic logic [63:0] model(input int n, input int k, input int l,
                                        input logic [31:0] a, input logic [31:0] b);
    int m = n - k;
    logic [63:0] lo = '0;
    logic [63:0] hi;
    logic [63:0] km = (64'd1 << k) - 64'd1;
    for (int i = 0; i < m; i++) begin
      logic c;
      if (i < l) lo[i] = 1'b1;
      else begin
        c = (i > l) ? (a[i-1] & b[i-1]) : 1'b0;
        lo[i] = ((i == m-1) ? (a[i] ^ b[i]) : (a[i] | b[i])) | c;
      end
    end
    hi = ((64'(a) >> m) & km) + ((64'(b) >> m) & km) + 64'(a[m-1] & b[m-1]);
    return (hi << m) | lo;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    int err_d = 0;
    int err_l0 = 0;
    real rate, want;
    aw = '0; bw = '0; an = '0; bn = '0;
    repeat (2) @(posedge clk);

    foreach (VEC[v]) begin
      @(posedge clk);
      aw = VEC[v][48:33]; bw = VEC[v][32:17];
      @(negedge clk);
      check($sformatf("R1-table vector %0d", v), {47'd0, c_d, s_d}, {47'd0, VEC[v][0], VEC[v][16:1]});
    end

    // R2: bits below the top approx position do not disturb the exact part
    @(posedge clk); aw = 16'h127F; bw = 16'h347F;
    @(negedge clk); check("R2 upper with low carries", {47'd0, c_d, s_d[15:8]}, 64'h46);

    // R9 boundaries: empty OR region and single-bit approx field, exhaustive
    for (int x = 0; x < 65536; x++) begin
      @(posedge clk);
      an = x[7:0]; bn = x[15:8];
      @(negedge clk);
      check("R9 empty OR region (R4 no carry term)", {55'd0, c_e, s_e}, model(8, 4, 3, 32'(an), 32'(bn)));
      check("R6 single approx bit is exact", {55'd0, c_z, s_z}, 64'(an) + 64'(bn));
    end

    // R8: random run, bit-exact model and error rate
    for (int r = 0; r < 20000; r++) begin
      @(posedge clk);
      aw = 16'($urandom); bw = 16'($urandom);
      @(negedge clk);
      check("R3 R4 R5 model fill=4", {47'd0, c_d, s_d}, model(16, 8, 4, 32'(aw), 32'(bw)));
      check("R3 R4 model fill=0", {47'd0, c_l0, s_l0}, model(16, 8, 0, 32'(aw), 32'(bw)));
      if ({c_d, s_d} != 17'(aw) + 17'(bw)) err_d++;
      if ({c_l0, s_l0} != 17'(aw) + 17'(bw)) err_l0++;
    end
    rate = real'(err_d) / 20000.0;
    want = 1.0 - (0.75 ** 3) * (0.5 ** 4);
    tests++;
    if (rate - want > 0.015 || want - rate > 0.015) begin
      fails++;
      $display("FAIL R8 fill=4 error rate actual=%f expected=%f", rate, want);
    end
    rate = real'(err_l0) / 20000.0;
    want = 1.0 - (0.75 ** 7);
    tests++;
    if (rate - want > 0.015 || want - rate > 0.015) begin
      fails++;
      $display("FAIL R8 fill=0 error rate actual=%f expected=%f", rate, want);
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 190000 && !done; c++) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule